// File: doc/BRIEF.md
# In-Order Retire Unit

This block sits between the execution units and the architectural register file of an out-of-order core. The dispatcher allocates one slot per instruction into a circular completion buffer, in program order, and receives that slot's index. When an execution unit finishes an instruction it reports the slot index, the rename register that holds the result, the result value and a set of fault flags. The retire logic inspects the oldest slots every cycle and commits, in program order, the longest run of finished and fault-free slots, up to the retire width.

Each committed slot drives its own architectural write port (destination register and result value) and its own free-list port that hands the rename register back. Slot 0 of those ports always carries the oldest instruction. When the scan reaches a finished slot that carries fault flags, that slot is not committed. The block reports its index and flags for one cycle and discards it together with every younger slot, so that the dispatcher refills from the faulting position.

Top module: `retire_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `alloc_ready` is 1, `alloc_idx` is 0, and `arf_we`, `free_valid` and `exc_valid` are all 0.
- R2: Each accepted allocation takes the slot shown on `alloc_idx`, and the next one takes the following slot modulo DEPTH. When DEPTH slots are occupied, `alloc_ready` is 0, and a request on `alloc_valid` changes neither `alloc_idx` nor any stored slot.
- R3: Retirement stops at the first occupied slot that has not been reported complete. Younger slots that are already complete stay in the buffer until every older slot has retired.
- R4: In one cycle, up to RET_W consecutive complete slots retire, starting at the oldest. Write port s (bit s of `arf_we`, field s of `arf_dest` and `arf_data`) carries the s-th oldest slot. It shows the destination given at allocation and the value given at completion. The outputs reflect the current buffer contents, and the retire takes effect at the next clock edge.
- R5: For every slot retiring in a cycle, `free_valid` bit s is 1 and field s of `free_preg` holds the rename register reported at that slot's completion.
- R6: A complete slot with nonzero fault flags never retires. When every older slot within the scan window retires, `exc_valid` is 1, `exc_idx` is the slot index and `exc_flags` holds its flags. In the same cycle the older slots retire on the lower write ports and `alloc_ready` is 0.
- R7: At the clock edge that ends a cycle with `exc_valid` at 1, the faulting slot and all younger slots are discarded. In the next cycle `exc_valid` is 0, `alloc_ready` is 1 and `alloc_idx` equals the faulting index, and a discarded slot never retires.
- R8: A completion report for a slot that is not occupied has no effect. A later allocation of that slot must be reported complete again before the slot retires.
- R9: Slot indices wrap from DEPTH-1 to 0, and retirement proceeds across the wrap in program order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Dispatcher requests one slot |
| alloc_dest | input | AREG_W | Architectural destination of the allocated instruction |
| alloc_ready | output | 1 | A request is accepted this cycle |
| alloc_idx | output | IDX_W | Slot the next accepted request takes |
| cmp_valid | input | 1 | Completion report |
| cmp_idx | input | IDX_W | Slot being reported complete |
| cmp_preg | input | PREG_W | Rename register holding the result |
| cmp_value | input | DATA_W | Result value, stored into that rename register |
| cmp_exc | input | EXC_W | Fault flags, zero for a clean result |
| arf_we | output | RET_W | Write enable per retire port, bit 0 oldest |
| arf_dest | output | RET_W*AREG_W | Destination register per retire port |
| arf_data | output | RET_W*DATA_W | Value per retire port |
| free_valid | output | RET_W | Rename register returned per retire port |
| free_preg | output | RET_W*PREG_W | Returned rename register per port |
| exc_valid | output | 1 | The oldest unretired slot in the window faulted |
| exc_idx | output | IDX_W | Index of the faulting slot |
| exc_flags | output | EXC_W | Fault flags of that slot |

## Verification
The bench builds the unit with an 8-slot buffer, a retire width of four, 32 architectural and 64 rename registers, 32-bit values and four fault flags. The small buffer makes the full condition and the index wrap reachable within a dozen allocations. With the width set to four, a single late completion can release a full four-wide group and leave a partial group behind it. A fault can also meet older instructions retiring on the lower ports in the same cycle, and a flush can land just past the wrap point.

// File: rtl/retire_pkg.sv
// Package: shared helpers for the retire unit.
// Assumes ring sizes are powers of two so index arithmetic wraps naturally.
package retire_pkg;

    // Retire width the unit is designed around
    localparam int RETIRE_WIDTH_DEFAULT = 4;

    // Number of set bits in a retire mask, used to advance the head pointer
    function automatic int unsigned mask_weight(input logic [31:0] mask);
        int unsigned n;
        n = 0;
        for (int i = 0; i < 32; i++) begin
            n += int'(mask[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/retire_scan.sv
// Module: retire_scan
// Looks at up to RET_W slots starting at the head and decides which retire.
// The run ends at the first slot that is out of range, unfinished or faulted.
// A faulted finished slot reached by the run is reported as an exception.
// Assumes DEPTH is a power of two and RET_W <= DEPTH.
module retire_scan #(
    parameter int DEPTH = 16,
    parameter int RET_W = 4,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic [IDX_W-1:0]       head,
    input  logic [CNT_W-1:0]       count,
    input  logic [DEPTH-1:0]       done,
    input  logic [DEPTH-1:0]       fault,
    output logic [RET_W-1:0]       commit,
    output logic [RET_W*IDX_W-1:0] slot_pos,
    output logic [CNT_W-1:0]       n_ret,
    output logic                   raise,
    output logic [IDX_W-1:0]       fault_pos
);

    // Walk the window oldest first and stop at the first blocker
    always_comb begin
        logic             run;
        logic [IDX_W-1:0] pos;
        run       = 1'b1;
        commit    = '0;
        n_ret     = '0;
        raise     = 1'b0;
        fault_pos = head;
        slot_pos  = '0;
        for (int s = 0; s < RET_W; s++) begin
            pos = head + IDX_W'(s);
            slot_pos[s*IDX_W +: IDX_W] = pos;
            if (run && (CNT_W'(s) < count) && done[pos]) begin
                if (fault[pos]) begin
                    raise     = 1'b1;
                    fault_pos = pos;
                    run       = 1'b0;
                end else begin
                    commit[s] = 1'b1;
                    n_ret     = n_ret + 1'b1;
                end
            end else begin
                run = 1'b0;
            end
        end
    end

endmodule

// File: rtl/rename_store.sv
// Module: rename_store
// Holds result values by rename register: one write port, RET_W read ports.
// Assumes a value is written before any retire port reads it; no reset on data.
module rename_store #(
    parameter int PREGS  = 64,
    parameter int DATA_W = 32,
    parameter int RET_W  = 4,
    localparam int PREG_W = $clog2(PREGS)
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [PREG_W-1:0]       waddr,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [RET_W*PREG_W-1:0] raddr,
    output logic [RET_W*DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [PREGS];

    // Store a completed result into its rename register
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // One combinational read per retire port
    for (genvar s = 0; s < RET_W; s++) begin : g_rd
        assign rdata[s*DATA_W +: DATA_W] = mem[raddr[s*PREG_W +: PREG_W]];
    end

endmodule

// File: rtl/retire_unit.sv
// Module: retire_unit
// Circular completion buffer with in-order, multi-wide retirement.
// Slots are allocated at the tail, completed in any order, retired from the
// head. A faulted slot stops retirement, is reported, and is flushed together
// with all younger slots. Assumes DEPTH is a power of two, RET_W <= DEPTH, and
// at most one completion report per cycle.
module retire_unit #(
    parameter int DEPTH  = 16,
    parameter int RET_W  = 4,
    parameter int AREGS  = 32,
    parameter int PREGS  = 64,
    parameter int DATA_W = 32,
    parameter int EXC_W  = 4,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int CNT_W  = IDX_W + 1,
    localparam int AREG_W = $clog2(AREGS),
    localparam int PREG_W = $clog2(PREGS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    alloc_valid,
    input  logic [AREG_W-1:0]       alloc_dest,
    output logic                    alloc_ready,
    output logic [IDX_W-1:0]        alloc_idx,
    input  logic                    cmp_valid,
    input  logic [IDX_W-1:0]        cmp_idx,
    input  logic [PREG_W-1:0]       cmp_preg,
    input  logic [DATA_W-1:0]       cmp_value,
    input  logic [EXC_W-1:0]        cmp_exc,
    output logic [RET_W-1:0]        arf_we,
    output logic [RET_W*AREG_W-1:0] arf_dest,
    output logic [RET_W*DATA_W-1:0] arf_data,
    output logic [RET_W-1:0]        free_valid,
    output logic [RET_W*PREG_W-1:0] free_preg,
    output logic                    exc_valid,
    output logic [IDX_W-1:0]        exc_idx,
    output logic [EXC_W-1:0]        exc_flags
);

    logic [IDX_W-1:0]  head_q, tail_q;
    logic [CNT_W-1:0]  count_q;
    logic [DEPTH-1:0]  valid_q, done_q, fault_vec;
    logic [EXC_W-1:0]  exc_q  [DEPTH];
    logic [PREG_W-1:0] preg_q [DEPTH];
    logic [AREG_W-1:0] dest_q [DEPTH];

    logic [RET_W-1:0]        commit;
    logic [RET_W*IDX_W-1:0]  slot_pos;
    logic [CNT_W-1:0]        n_ret;
    logic                    raise;
    logic [IDX_W-1:0]        fault_pos;
    logic [RET_W*PREG_W-1:0] rd_preg;
    logic                    alloc_fire, cmp_take;

    // Per-slot fault summary for the scan
    for (genvar i = 0; i < DEPTH; i++) begin : g_fault
        assign fault_vec[i] = |exc_q[i];
    end

    retire_scan #(.DEPTH(DEPTH), .RET_W(RET_W)) u_scan (
        .head      (head_q),
        .count     (count_q),
        .done      (done_q),
        .fault     (fault_vec),
        .commit    (commit),
        .slot_pos  (slot_pos),
        .n_ret     (n_ret),
        .raise     (raise),
        .fault_pos (fault_pos)
    );

    rename_store #(.PREGS(PREGS), .DATA_W(DATA_W), .RET_W(RET_W)) u_store (
        .clk   (clk),
        .we    (cmp_take),
        .waddr (cmp_preg),
        .wdata (cmp_value),
        .raddr (rd_preg),
        .rdata (arf_data)
    );

    // Handshake decisions for allocation and completion
    always_comb begin
        alloc_ready = (count_q != CNT_W'(DEPTH)) && !raise;
        alloc_fire  = alloc_valid && alloc_ready;
        cmp_take    = cmp_valid && valid_q[cmp_idx] && !done_q[cmp_idx];
    end

    assign alloc_idx = tail_q;
    assign arf_we     = commit;
    assign free_valid = commit;
    assign exc_valid  = raise;
    assign exc_idx    = fault_pos;
    assign exc_flags  = exc_q[fault_pos];

    // Route each retiring slot's payload to its port
    for (genvar s = 0; s < RET_W; s++) begin : g_port
        logic [IDX_W-1:0] p;
        assign p = slot_pos[s*IDX_W +: IDX_W];
        assign arf_dest[s*AREG_W +: AREG_W] = dest_q[p];
        assign rd_preg[s*PREG_W +: PREG_W]  = preg_q[p];
        assign free_preg[s*PREG_W +: PREG_W] = preg_q[p];
    end

    // Pointer, occupancy and slot-state update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
            valid_q <= '0;
            done_q  <= '0;
        end else begin
            head_q <= head_q + IDX_W'(n_ret);
            if (raise) begin
                tail_q  <= fault_pos;
                count_q <= '0;
                valid_q <= '0;
            end else begin
                tail_q  <= tail_q + IDX_W'(alloc_fire);
                count_q <= count_q + CNT_W'(alloc_fire) - n_ret;
                for (int s = 0; s < RET_W; s++) begin
                    if (commit[s]) begin
                        valid_q[slot_pos[s*IDX_W +: IDX_W]] <= 1'b0;
                    end
                end
                if (alloc_fire) begin
                    valid_q[tail_q] <= 1'b1;
                end
            end
            if (cmp_take) begin
                done_q[cmp_idx] <= 1'b1;
            end
            if (alloc_fire) begin
                done_q[tail_q] <= 1'b0;
            end
        end
    end

    // Payload capture at allocation and completion
    always_ff @(posedge clk) begin
        if (alloc_fire) begin
            dest_q[tail_q] <= alloc_dest;
        end
        if (cmp_take) begin
            preg_q[cmp_idx] <= cmp_preg;
            exc_q[cmp_idx]  <= cmp_exc;
        end
    end

    // A full buffer must not move the tail unless a flush happens
    assert_full_holds_tail_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == CNT_W'(DEPTH) && alloc_valid && !exc_valid) |=> $stable(alloc_idx));

    // Occupancy never exceeds the ring size
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH));

    // A faulted slot is never written; at least its own port stays idle
    assert_fault_not_written_R6: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> ($countones(arf_we) < RET_W));

    // The flush rewinds allocation to the faulting slot and clears the report
    assert_flush_rewind_R7: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> (!exc_valid && alloc_ready && alloc_idx == $past(exc_idx)));

    // A report for an empty slot leaves its completion state alone
    assert_stray_report_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !valid_q[cmp_idx] && !(alloc_fire && tail_q == cmp_idx))
        |=> done_q[$past(cmp_idx)] == $past(done_q[cmp_idx]));

endmodule

// File: tb/tb_retire_unit.sv
// Bench: vector table walk, then directed fault, flush, stray-report,
// full-buffer and reset cases.
module tb_retire_unit;

    localparam int DEPTH = 8, RET_W = 4, AREGS = 32, PREGS = 64, DATA_W = 32, EXC_W = 4;
    localparam int IDX_W = 3, AREG_W = 5, PREG_W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_valid = 1'b0;
    logic [AREG_W-1:0] alloc_dest = '0;
    logic alloc_ready;
    logic [IDX_W-1:0] alloc_idx;
    logic cmp_valid = 1'b0;
    logic [IDX_W-1:0] cmp_idx = '0;
    logic [PREG_W-1:0] cmp_preg = '0;
    logic [DATA_W-1:0] cmp_value = '0;
    logic [EXC_W-1:0] cmp_exc = '0;
    logic [RET_W-1:0] arf_we;
    logic [RET_W*AREG_W-1:0] arf_dest;
    logic [RET_W*DATA_W-1:0] arf_data;
    logic [RET_W-1:0] free_valid;
    logic [RET_W*PREG_W-1:0] free_preg;
    logic exc_valid;
    logic [IDX_W-1:0] exc_idx;
    logic [EXC_W-1:0] exc_flags;

    always #4 clk = ~clk;

    retire_unit #(.DEPTH(DEPTH), .RET_W(RET_W), .AREGS(AREGS), .PREGS(PREGS),
                  .DATA_W(DATA_W), .EXC_W(EXC_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_dest(alloc_dest),
        .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
        .cmp_valid(cmp_valid), .cmp_idx(cmp_idx), .cmp_preg(cmp_preg),
        .cmp_value(cmp_value), .cmp_exc(cmp_exc),
        .arf_we(arf_we), .arf_dest(arf_dest), .arf_data(arf_data),
        .free_valid(free_valid), .free_preg(free_preg),
        .exc_valid(exc_valid), .exc_idx(exc_idx), .exc_flags(exc_flags)
    );

    int n_chk = 0;
    int n_bad = 0;
    int hd = 0;
    int mt = 0;
    int m_dest [DEPTH];
    int m_preg [DEPTH];
    int m_val  [DEPTH];

    // Fields: kind(2: 0 idle,1 alloc,2 complete) idx(3) dest(5) preg(6) val(16) exc(4) mask(4)
    localparam int NV = 14;
    localparam logic [39:0] VEC [NV] = '{
        {2'd1, 3'd0, 5'd1, 6'd0,  16'h0000, 4'h0, 4'b0000},
        {2'd1, 3'd0, 5'd2, 6'd0,  16'h0000, 4'h0, 4'b0000},
        {2'd1, 3'd0, 5'd3, 6'd0,  16'h0000, 4'h0, 4'b0000},
        {2'd1, 3'd0, 5'd4, 6'd0,  16'h0000, 4'h0, 4'b0000},
        {2'd1, 3'd0, 5'd5, 6'd0,  16'h0000, 4'h0, 4'b0000},
        {2'd1, 3'd0, 5'd6, 6'd0,  16'h0000, 4'h0, 4'b0000},
        {2'd2, 3'd1, 5'd0, 6'd11, 16'h0A01, 4'h0, 4'b0000},
        {2'd2, 3'd2, 5'd0, 6'd12, 16'h0A02, 4'h0, 4'b0000},
        {2'd2, 3'd3, 5'd0, 6'd13, 16'h0A03, 4'h0, 4'b0000},
        {2'd2, 3'd5, 5'd0, 6'd15, 16'h0A05, 4'h0, 4'b0000},
        {2'd2, 3'd0, 5'd0, 6'd10, 16'h0A00, 4'h0, 4'b1111},
        {2'd0, 3'd0, 5'd0, 6'd0,  16'h0000, 4'h0, 4'b0000},
        {2'd2, 3'd4, 5'd0, 6'd14, 16'h0A04, 4'h0, 4'b0011},
        {2'd0, 3'd0, 5'd0, 6'd0,  16'h0000, 4'h0, 4'b0000}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, release just after the rising edge
    task automatic drive(input bit a, input bit take, input int dest,
                         input bit c, input int idx, input int preg, input int val, input int exc);
        @(negedge clk);
        alloc_valid = a;
        alloc_dest  = AREG_W'(dest);
        cmp_valid   = c;
        cmp_idx     = IDX_W'(idx);
        cmp_preg    = PREG_W'(preg);
        cmp_value   = DATA_W'(val);
        cmp_exc     = EXC_W'(exc);
        if (a && take) begin
            check("R2 alloc index", 64'(alloc_idx), 64'(mt));
            m_dest[mt] = dest;
        end
        if (c) begin
            m_preg[idx] = preg;
            m_val[idx]  = val;
        end
        @(posedge clk);
        #1;
        alloc_valid = 1'b0;
        cmp_valid   = 1'b0;
        if (a && take) mt = (mt + 1) % DEPTH;
    endtask

    // Compare retire ports against the model; retired slots leave at the next edge
    task automatic check_retire(input string req, input logic [3:0] mask);
        int e;
        check({req, " write enables"}, 64'(arf_we), 64'(mask));
        check({req, " R5 free enables"}, 64'(free_valid), 64'(mask));
        for (int s = 0; s < RET_W; s++) begin
            if (mask[s]) begin
                e = (hd + s) % DEPTH;
                check({req, " R4 dest"}, 64'(arf_dest[s*AREG_W +: AREG_W]), 64'(m_dest[e]));
                check({req, " R4 data"}, 64'(arf_data[s*DATA_W +: DATA_W]), 64'(m_val[e]));
                check({req, " R5 preg"}, 64'(free_preg[s*PREG_W +: PREG_W]), 64'(m_preg[e]));
            end
        end
        hd = (hd + $countones(mask)) % DEPTH;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check("R1 ready in reset", 64'(alloc_ready), 64'd1);
        check("R1 no write in reset", 64'(arf_we), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        hd = 0;
        mt = 0;
        @(posedge clk);
        #1;
        check("R1 ready", 64'(alloc_ready), 64'd1);
        check("R1 index", 64'(alloc_idx), 64'd0);
        check("R1 write", 64'(arf_we), 64'd0);
        check("R1 free", 64'(free_valid), 64'd0);
        check("R1 exc", 64'(exc_valid), 64'd0);
    endtask

    // Watchdog: an expired run counts as one failed check
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        do_reset();

        // Table walk: in-order groups R3, R4
        for (int v = 0; v < NV; v++) begin
            logic [39:0] w;
            w = VEC[v];
            drive(w[39:38] == 2'd1, 1'b1, int'(w[34:30]),
                  w[39:38] == 2'd2, int'(w[37:35]), int'(w[29:24]),
                  int'(w[23:8]), int'(w[7:4]));
            check_retire("R3 R4 table", w[3:0]);
        end

        // Fault and flush across the wrap R6 R7 R9
        drive(1, 1, 10, 0, 0, 0, 0, 0); check_retire("R9 alloc", 4'b0000);
        drive(1, 1, 11, 0, 0, 0, 0, 0); check_retire("R9 alloc", 4'b0000);
        drive(1, 1, 12, 0, 0, 0, 0, 0); check_retire("R9 alloc", 4'b0000);
        drive(1, 1, 13, 0, 0, 0, 0, 0); check_retire("R9 alloc", 4'b0000);
        drive(0, 0, 0, 1, 0, 20, 32'hA0, 0); check_retire("R3 past wrap waits", 4'b0000);
        drive(0, 0, 0, 1, 6, 21, 32'hA6, 0); check_retire("R9 head retires", 4'b0001);
        drive(0, 0, 0, 1, 7, 22, 32'hA7, 2); check_retire("R6 fault blocks", 4'b0000);
        check("R6 exc valid", 64'(exc_valid), 64'd1);
        check("R6 exc idx", 64'(exc_idx), 64'd7);
        check("R6 exc flags", 64'(exc_flags), 64'd2);
        check("R6 alloc blocked", 64'(alloc_ready), 64'd0);
        drive(0, 0, 0, 0, 0, 0, 0, 0); check_retire("R7 flushed none retire", 4'b0000);
        mt = 7;
        check("R7 exc cleared", 64'(exc_valid), 64'd0);
        check("R7 ready", 64'(alloc_ready), 64'd1);
        check("R7 rewind", 64'(alloc_idx), 64'd7);
        drive(1, 1, 14, 0, 0, 0, 0, 0); check_retire("R7 refill", 4'b0000);
        drive(1, 1, 15, 0, 0, 0, 0, 0); check_retire("R7 refill", 4'b0000);
        drive(0, 0, 0, 1, 7, 23, 32'hB7, 0); check_retire("R7 stale done gone", 4'b0001);
        drive(0, 0, 0, 0, 0, 0, 0, 0); check_retire("R7 new slot waits", 4'b0000);

        // Fault with an older slot retiring in the same cycle R6
        drive(1, 1, 16, 0, 0, 0, 0, 0); check_retire("R6 alloc", 4'b0000);
        drive(0, 0, 0, 1, 1, 25, 32'hC1, 8); check_retire("R6 younger fault waits", 4'b0000);
        check("R6 no exc yet", 64'(exc_valid), 64'd0);
        drive(0, 0, 0, 1, 0, 24, 32'hC0, 0); check_retire("R6 older retires", 4'b0001);
        check("R6 exc same cycle", 64'(exc_valid), 64'd1);
        check("R6 exc idx", 64'(exc_idx), 64'd1);
        check("R6 exc flags", 64'(exc_flags), 64'd8);
        drive(0, 0, 0, 0, 0, 0, 0, 0); check_retire("R7 after flush", 4'b0000);
        mt = 1;
        check("R7 rewind", 64'(alloc_idx), 64'd1);

        // Stray completion to an empty slot R8
        drive(0, 0, 0, 1, 3, 30, 32'hDD, 0); check_retire("R8 stray", 4'b0000);
        drive(1, 1, 17, 0, 0, 0, 0, 0); check_retire("R8 alloc", 4'b0000);
        drive(1, 1, 18, 0, 0, 0, 0, 0); check_retire("R8 alloc", 4'b0000);
        drive(1, 1, 19, 0, 0, 0, 0, 0); check_retire("R8 alloc", 4'b0000);
        drive(0, 0, 0, 1, 2, 31, 32'hE2, 0); check_retire("R8 wait head", 4'b0000);
        drive(0, 0, 0, 1, 1, 32, 32'hE1, 0); check_retire("R8 stray not done", 4'b0011);
        drive(0, 0, 0, 0, 0, 0, 0, 0); check_retire("R8 idle", 4'b0000);
        drive(0, 0, 0, 1, 3, 33, 32'hE3, 0); check_retire("R8 fresh value", 4'b0001);

        // Full buffer R2, after a fresh reset R1
        do_reset();
        for (int k = 1; k <= DEPTH; k++) begin
            drive(1, 1, k, 0, 0, 0, 0, 0);
        end
        check("R2 full not ready", 64'(alloc_ready), 64'd0);
        drive(1, 0, 31, 0, 0, 0, 0, 0); check_retire("R2 ignored alloc", 4'b0000);
        check("R2 full index held", 64'(alloc_idx), 64'd0);
        check("R2 still not ready", 64'(alloc_ready), 64'd0);
        drive(0, 0, 0, 1, 0, 40, 32'hF0, 0); check_retire("R2 dest untouched", 4'b0001);
        drive(0, 0, 0, 0, 0, 0, 0, 0); check_retire("R2 idle", 4'b0000);
        check("R2 ready after retire", 64'(alloc_ready), 64'd1);
        check("R2 index after retire", 64'(alloc_idx), 64'd0);
        drive(0, 0, 0, 1, 1, 41, 32'hF1, 0); check_retire("R2 next slot", 4'b0001);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule